// File: doc/BRIEF.md
# Processor exception entry controller

This block holds the control registers that a small 32-bit soft processor touches when it takes an exception or an interrupt. These are the status word, the saved status, the break status, the exception-cause register, the TLB miscellaneous register, and the two return-address registers: one for exceptions and one for breaks. The core raises a one-cycle request carrying a class, a cause code and the PC of the faulting instruction. In that cycle the controller updates the registers according to the class and to the handler-active bit already in status. One cycle after the request it presents the redirect PC together with a load strobe.

A TLB miss that arrives while a handler is already running is treated as a nested miss. It is sent to the general vector and keeps the first miss's saved context. Breaks save into their own pair of registers, so a debugger can interrupt an exception handler without losing that handler's context. The core's control-register write path updates any of the held registers. A request in the same cycle takes precedence over that write.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On every accepted request, bits 6:2 of the cause register take the low 5 bits of the cause input, and every other bit of that register keeps its value.
- R2: Every accepted request leaves status bit 0 (previous interrupt enable) and status bit 1 (user mode) at zero.
- R3: Class 3'd0 (hardware interrupt) copies status into saved-status, sets status bit 3 (interrupt handler), writes PC+4 into the exception return register and redirects to EXC_VEC.
- R4: Class 3'd1 (TLB miss) with status bit 2 (handler active) clear copies status into saved-status, sets status bit 2, clears TLB-misc bit 3 (nested miss), sets TLB-misc bit 18 (write pending), writes PC+4 into the exception return register and redirects to FAST_VEC.
- R5: Class 3'd1 with status bit 2 set sets TLB-misc bit 3 and redirects to EXC_VEC, and leaves saved-status and the exception return register unchanged.
- R6: Classes 3'd3 (supervisor-only) and 3'd4 (trap) save status and PC+4 into saved-status and the exception return register only when status bit 2 was clear. Both always set status bit 2 and redirect to EXC_VEC.
- R7: Class 3'd5 (break) saves status and PC+4 into break-status and the break return register only when status bit 2 was clear. It never touches saved-status or the exception return register, sets status bit 2 and redirects to EXC_VEC.
- R8: Class 3'd2 (TLB permission) always saves status and PC+4 and sets status bit 2. It sets TLB-misc bit 18 only when status bit 2 was clear beforehand, and redirects to EXC_VEC.
- R9: Class codes 3'd6 and 3'd7 set a sticky error output and change no register, and they produce no load strobe.
- R10: The redirect PC and the load strobe are registered. The strobe is high for exactly the one cycle after an accepted request.
- R11: Synchronous reset clears every held register, the redirect PC, the strobe and the error output.
- R12: The write port selects a register by code (0 status, 1 saved-status, 2 break-status, 3 cause, 4 TLB-misc, 5 exception return, 6 break return). A write is ignored in any cycle that carries a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Exception request, one cycle |
| cls_i | input | 3 | Exception class code |
| cause_i | input | 8 | Cause code, low 5 bits used |
| pc_i | input | 32 | PC of the excepting instruction |
| csr_we_i | input | 1 | Control-register write enable |
| csr_sel_i | input | 3 | Control-register select |
| csr_wdata_i | input | 32 | Control-register write data |
| status_o | output | 32 | Status register |
| estatus_o | output | 32 | Saved status |
| bstatus_o | output | 32 | Break status |
| cause_reg_o | output | 32 | Exception cause register |
| tlbmisc_o | output | 32 | TLB miscellaneous register |
| eret_o | output | 32 | Exception return address |
| bret_o | output | 32 | Break return address |
| new_pc_o | output | 32 | Redirect PC |
| pc_load_o | output | 1 | Redirect strobe |
| class_err_o | output | 1 | Sticky illegal-class flag |

## Verification
The assertions check the following on every cycle: the cause-field merge, the clearing of the mode bits, the vector choice and nested-miss flagging for TLB misses, the hold of the exception save registers on nested misses and on breaks, the sticky error with no side effects, and the origin of each load strobe. Only the bench scenarios can show the exact saved-status and return-address values for each class with the handler bit clear and set. They also cover the interrupt-handler bit, the conditional write-pending flag on permission faults, and the precedence of a request over a same-cycle register write.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam logic [2:0] CLS_IRQ      = 3'd0;
  localparam logic [2:0] CLS_TLB_MISS = 3'd1;
  localparam logic [2:0] CLS_TLB_PERM = 3'd2;
  localparam logic [2:0] CLS_SUPER    = 3'd3;
  localparam logic [2:0] CLS_TRAP     = 3'd4;
  localparam logic [2:0] CLS_BREAK    = 3'd5;

  localparam int ST_PIE = 0;
  localparam int ST_U   = 1;
  localparam int ST_EH  = 2;
  localparam int ST_IH  = 3;
  localparam int TM_DBL = 3;
  localparam int TM_WR  = 18;
  localparam int CAUSE_LSB = 2;
  localparam int CAUSE_W   = 5;

  localparam logic [2:0] SEL_STATUS  = 3'd0;
  localparam logic [2:0] SEL_ESTATUS = 3'd1;
  localparam logic [2:0] SEL_BSTATUS = 3'd2;
  localparam logic [2:0] SEL_CAUSE   = 3'd3;
  localparam logic [2:0] SEL_TLBMISC = 3'd4;
  localparam logic [2:0] SEL_ERET    = 3'd5;
  localparam logic [2:0] SEL_BRET    = 3'd6;

  typedef struct packed {
    logic legal;
    logic save_exc;
    logic save_brk;
    logic set_ih;
    logic set_eh;
    logic tm_clr_dbl;
    logic tm_set_dbl;
    logic tm_set_wr;
    logic fast_vec;
  } exc_action_t;
endpackage

// File: rtl/exc_entry_decode.sv
module exc_entry_decode
  import exc_entry_pkg::*;
(
  input  logic [2:0]  cls_i,
  input  logic        eh_i,
  output exc_action_t act_o
);
  always_comb begin
    act_o = '0;
    case (cls_i)
      CLS_IRQ: begin
        act_o.legal    = 1'b1;
        act_o.save_exc = 1'b1;
        act_o.set_ih   = 1'b1;
      end
      CLS_TLB_MISS: begin
        act_o.legal  = 1'b1;
        act_o.set_eh = 1'b1;
        if (!eh_i) begin
          act_o.save_exc   = 1'b1;
          act_o.tm_clr_dbl = 1'b1;
          act_o.tm_set_wr  = 1'b1;
          act_o.fast_vec   = 1'b1;
        end else begin
          act_o.tm_set_dbl = 1'b1;
        end
      end
      CLS_TLB_PERM: begin
        act_o.legal     = 1'b1;
        act_o.set_eh    = 1'b1;
        act_o.save_exc  = 1'b1;
        act_o.tm_set_wr = !eh_i;
      end
      CLS_SUPER, CLS_TRAP: begin
        act_o.legal    = 1'b1;
        act_o.set_eh   = 1'b1;
        act_o.save_exc = !eh_i;
      end
      CLS_BREAK: begin
        act_o.legal    = 1'b1;
        act_o.set_eh   = 1'b1;
        act_o.save_brk = !eh_i;
      end
      default: act_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_entry_redirect.sv
module exc_entry_redirect #(
  parameter int                 XLEN     = 32,
  parameter logic [XLEN-1:0]    EXC_VEC  = 32'h0000_0020,
  parameter logic [XLEN-1:0]    FAST_VEC = 32'h0000_0200
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic            fast_i,
  output logic [XLEN-1:0] new_pc_o,
  output logic            pc_load_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      new_pc_o  <= '0;
      pc_load_o <= 1'b0;
    end else begin
      pc_load_o <= take_i;
      if (take_i) new_pc_o <= fast_i ? FAST_VEC : EXC_VEC;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CAUSE_IN = 8,
  parameter logic [XLEN-1:0] EXC_VEC  = 32'h0000_0020,
  parameter logic [XLEN-1:0] FAST_VEC = 32'h0000_0200
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic [2:0]          cls_i,
  input  logic [CAUSE_IN-1:0] cause_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic                csr_we_i,
  input  logic [2:0]          csr_sel_i,
  input  logic [XLEN-1:0]     csr_wdata_i,
  output logic [XLEN-1:0]     status_o,
  output logic [XLEN-1:0]     estatus_o,
  output logic [XLEN-1:0]     bstatus_o,
  output logic [XLEN-1:0]     cause_reg_o,
  output logic [XLEN-1:0]     tlbmisc_o,
  output logic [XLEN-1:0]     eret_o,
  output logic [XLEN-1:0]     bret_o,
  output logic [XLEN-1:0]     new_pc_o,
  output logic                pc_load_o,
  output logic                class_err_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);
  localparam logic [XLEN-1:0] CAUSE_MASK = XLEN'(((1 << CAUSE_W) - 1) << CAUSE_LSB);

  exc_action_t     act;
  logic            take;
  logic [XLEN-1:0] ret_addr;
  logic [XLEN-1:0] status_nx;
  logic [XLEN-1:0] cause_nx;
  logic [XLEN-1:0] tlbmisc_nx;

  exc_entry_decode u_decode (
    .cls_i (cls_i),
    .eh_i  (status_o[ST_EH]),
    .act_o (act)
  );

  assign take     = req_i && act.legal;
  assign ret_addr = pc_i + INSN_BYTES;

  always_comb begin
    status_nx = status_o;
    if (act.set_ih) status_nx[ST_IH] = 1'b1;
    if (act.set_eh) status_nx[ST_EH] = 1'b1;
    status_nx[ST_PIE] = 1'b0;
    status_nx[ST_U]   = 1'b0;

    cause_nx = (cause_reg_o & ~CAUSE_MASK)
             | (XLEN'(cause_i[CAUSE_W-1:0]) << CAUSE_LSB);

    tlbmisc_nx = tlbmisc_o;
    if (act.tm_clr_dbl) tlbmisc_nx[TM_DBL] = 1'b0;
    if (act.tm_set_dbl) tlbmisc_nx[TM_DBL] = 1'b1;
    if (act.tm_set_wr)  tlbmisc_nx[TM_WR]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o    <= '0;
      estatus_o   <= '0;
      bstatus_o   <= '0;
      cause_reg_o <= '0;
      tlbmisc_o   <= '0;
      eret_o      <= '0;
      bret_o      <= '0;
      class_err_o <= 1'b0;
    end else if (req_i) begin
      if (take) begin
        status_o    <= status_nx;
        cause_reg_o <= cause_nx;
        tlbmisc_o   <= tlbmisc_nx;
        if (act.save_exc) begin
          estatus_o <= status_o;
          eret_o    <= ret_addr;
        end
        if (act.save_brk) begin
          bstatus_o <= status_o;
          bret_o    <= ret_addr;
        end
      end else begin
        class_err_o <= 1'b1;
      end
    end else if (csr_we_i) begin
      case (csr_sel_i)
        SEL_STATUS:  status_o    <= csr_wdata_i;
        SEL_ESTATUS: estatus_o   <= csr_wdata_i;
        SEL_BSTATUS: bstatus_o   <= csr_wdata_i;
        SEL_CAUSE:   cause_reg_o <= csr_wdata_i;
        SEL_TLBMISC: tlbmisc_o   <= csr_wdata_i;
        SEL_ERET:    eret_o      <= csr_wdata_i;
        SEL_BRET:    bret_o      <= csr_wdata_i;
        default: ;
      endcase
    end
  end

  exc_entry_redirect #(
    .XLEN     (XLEN),
    .EXC_VEC  (EXC_VEC),
    .FAST_VEC (FAST_VEC)
  ) u_redirect (
    .clk       (clk),
    .rst       (rst),
    .take_i    (take),
    .fast_i    (act.fast_vec),
    .new_pc_o  (new_pc_o),
    .pc_load_o (pc_load_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CAUSE_IN = 8,
  parameter logic [XLEN-1:0] EXC_VEC  = 32'h0000_0020,
  parameter logic [XLEN-1:0] FAST_VEC = 32'h0000_0200
) (
  input logic                clk,
  input logic                rst,
  input logic                req_i,
  input logic [2:0]          cls_i,
  input logic [CAUSE_IN-1:0] cause_i,
  input logic [XLEN-1:0]     status_o,
  input logic [XLEN-1:0]     estatus_o,
  input logic [XLEN-1:0]     cause_reg_o,
  input logic [XLEN-1:0]     tlbmisc_o,
  input logic [XLEN-1:0]     eret_o,
  input logic [XLEN-1:0]     new_pc_o,
  input logic                pc_load_o,
  input logic                class_err_o
);
  logic ok_req;
  logic bad_req;
  assign ok_req  = req_i && (cls_i <= CLS_BREAK);
  assign bad_req = req_i && (cls_i > CLS_BREAK);

  p_cause_field_r1: assert property (@(posedge clk) disable iff (rst)
    ok_req |=> (cause_reg_o[6:2] == $past(cause_i[4:0]))
           && (cause_reg_o[1:0] == $past(cause_reg_o[1:0]))
           && (cause_reg_o[XLEN-1:7] == $past(cause_reg_o[XLEN-1:7])));

  p_mode_clear_r2: assert property (@(posedge clk) disable iff (rst)
    ok_req |=> !status_o[ST_PIE] && !status_o[ST_U]);

  p_fast_miss_r4: assert property (@(posedge clk) disable iff (rst)
    (req_i && cls_i == CLS_TLB_MISS && !status_o[ST_EH])
      |=> (new_pc_o == FAST_VEC) && tlbmisc_o[TM_WR] && !tlbmisc_o[TM_DBL]);

  p_nested_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (req_i && cls_i == CLS_TLB_MISS && status_o[ST_EH])
      |=> $stable(estatus_o) && $stable(eret_o) && tlbmisc_o[TM_DBL]
          && (new_pc_o == EXC_VEC));

  p_break_keeps_exc_r7: assert property (@(posedge clk) disable iff (rst)
    (req_i && cls_i == CLS_BREAK) |=> $stable(estatus_o) && $stable(eret_o));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    class_err_o |=> class_err_o);

  p_bad_class_hold_r9: assert property (@(posedge clk) disable iff (rst)
    bad_req |=> $stable(status_o) && $stable(cause_reg_o) && !pc_load_o && class_err_o);

  p_load_origin_r10: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> $past(ok_req));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN     (XLEN),
  .CAUSE_IN (CAUSE_IN),
  .EXC_VEC  (EXC_VEC),
  .FAST_VEC (FAST_VEC)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .cls_i       (cls_i),
  .cause_i     (cause_i),
  .status_o    (status_o),
  .estatus_o   (estatus_o),
  .cause_reg_o (cause_reg_o),
  .tlbmisc_o   (tlbmisc_o),
  .eret_o      (eret_o),
  .new_pc_o    (new_pc_o),
  .pc_load_o   (pc_load_o),
  .class_err_o (class_err_o)
);

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  localparam logic [31:0] EV = 32'h1000_0020;
  localparam logic [31:0] FV = 32'h1000_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [2:0]  cls = '0;
  logic [7:0]  cause = '0;
  logic [31:0] pc = '0;
  logic        we = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] status, estatus, bstatus, causer, tlbmisc, eret, bret, npc;
  logic        pcl, err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl #(.EXC_VEC(EV), .FAST_VEC(FV)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .cls_i(cls), .cause_i(cause), .pc_i(pc),
    .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
    .status_o(status), .estatus_o(estatus), .bstatus_o(bstatus),
    .cause_reg_o(causer), .tlbmisc_o(tlbmisc), .eret_o(eret), .bret_o(bret),
    .new_pc_o(npc), .pc_load_o(pcl), .class_err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); we = 1'b1; sel = s; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // drive a request; returns at the negedge after the capturing edge
  task automatic raise(input logic [2:0] c, input logic [7:0] cs, input logic [31:0] p);
    @(negedge clk); req = 1'b1; cls = c; cause = cs; pc = p;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 status", status, 0);   chk("R11 estatus", estatus, 0);
    chk("R11 bstatus", bstatus, 0); chk("R11 cause", causer, 0);
    chk("R11 tlbmisc", tlbmisc, 0); chk("R11 eret", eret, 0);
    chk("R11 bret", bret, 0);       chk("R11 newpc", npc, 0);
    chk("R11 pcload", {31'b0, pcl}, 0); chk("R11 err", {31'b0, err}, 0);
  endtask

  task automatic t_irq;
    csr_wr(3'd0, 32'h3);
    csr_wr(3'd3, 32'hFFFF_FFFF);
    raise(3'd0, 8'h25, 32'h0000_0400);
    chk("R1 cause merge", causer, 32'hFFFF_FF97);
    chk("R2/R3 status", status, 32'h8);
    chk("R3 estatus", estatus, 32'h3);
    chk("R3 eret", eret, 32'h404);
    chk("R3 newpc", npc, EV);
    chk("R10 pcload high", {31'b0, pcl}, 1);
    @(negedge clk);
    chk("R10 pcload pulse", {31'b0, pcl}, 0);
  endtask

  task automatic t_fast_miss;
    csr_wr(3'd0, 32'h3);
    csr_wr(3'd4, 32'h8);
    raise(3'd1, 8'd12, 32'h1000);
    chk("R4 estatus", estatus, 32'h3);
    chk("R4 status", status, 32'h4);
    chk("R4 tlbmisc", tlbmisc, 32'h0004_0000);
    chk("R4 eret", eret, 32'h1004);
    chk("R4 newpc", npc, FV);
  endtask

  task automatic t_nested_miss;
    csr_wr(3'd0, 32'h5);
    raise(3'd1, 8'd12, 32'h2000);
    chk("R5 status", status, 32'h4);
    chk("R5 estatus kept", estatus, 32'h3);
    chk("R5 eret kept", eret, 32'h1004);
    chk("R5 tlbmisc", tlbmisc, 32'h0004_0008);
    chk("R5 newpc", npc, EV);
  endtask

  task automatic t_trap_super;
    csr_wr(3'd0, 32'h1);
    raise(3'd4, 8'd3, 32'h3000);
    chk("R6 trap estatus", estatus, 32'h1);
    chk("R6 trap eret", eret, 32'h3004);
    chk("R6 trap status", status, 32'h4);
    chk("R6 trap newpc", npc, EV);
    csr_wr(3'd0, 32'h6);
    raise(3'd3, 8'd9, 32'h4000);
    chk("R6 super estatus kept", estatus, 32'h1);
    chk("R6 super eret kept", eret, 32'h3004);
    chk("R6/R2 super status", status, 32'h4);
    chk("R1 super cause", causer, 32'hFFFF_FFA7);
  endtask

  task automatic t_break;
    csr_wr(3'd0, 32'h3);
    raise(3'd5, 8'd7, 32'h5000);
    chk("R7 bstatus", bstatus, 32'h3);
    chk("R7 bret", bret, 32'h5004);
    chk("R7 estatus kept", estatus, 32'h1);
    chk("R7 eret kept", eret, 32'h3004);
    chk("R7 status", status, 32'h4);
    raise(3'd5, 8'd7, 32'h5800);
    chk("R7 nested bstatus kept", bstatus, 32'h3);
    chk("R7 nested bret kept", bret, 32'h5004);
    chk("R7 newpc", npc, EV);
  endtask

  task automatic t_perm;
    csr_wr(3'd0, 32'h1);
    csr_wr(3'd4, 32'h0);
    raise(3'd2, 8'd14, 32'h6000);
    chk("R8 estatus", estatus, 32'h1);
    chk("R8 eret", eret, 32'h6004);
    chk("R8 tlbmisc set", tlbmisc, 32'h0004_0000);
    chk("R8 status", status, 32'h4);
    csr_wr(3'd0, 32'h5);
    csr_wr(3'd4, 32'h0);
    raise(3'd2, 8'd14, 32'h7000);
    chk("R8 nested estatus", estatus, 32'h5);
    chk("R8 nested eret", eret, 32'h7004);
    chk("R8 nested tlbmisc", tlbmisc, 32'h0);
    chk("R8 newpc", npc, EV);
  endtask

  task automatic t_bad_class;
    logic [31:0] c0;
    csr_wr(3'd0, 32'h3);
    c0 = causer;
    raise(3'd6, 8'd1, 32'h8000);
    chk("R9 status held", status, 32'h3);
    chk("R9 cause held", causer, c0);
    chk("R9 no pcload", {31'b0, pcl}, 0);
    chk("R9 err set", {31'b0, err}, 1);
    raise(3'd7, 8'd1, 32'h8000);
    @(negedge clk);
    chk("R9 err sticky", {31'b0, err}, 1);
  endtask

  task automatic t_write_priority;
    csr_wr(3'd0, 32'h2);
    @(negedge clk);
    req = 1'b1; cls = 3'd4; cause = 8'd1; pc = 32'h9000;
    we = 1'b1; sel = 3'd0; wdata = 32'hFF;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R12 write ignored", status, 32'h4);
    csr_wr(3'd6, 32'hABCD_0000);
    chk("R12 bret write", bret, 32'hABCD_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL all watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_irq();
    t_fast_miss();
    t_nested_miss();
    t_trap_super();
    t_break();
    t_perm();
    t_bad_class();
    t_write_priority();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule